// File: doc/BRIEF.md
# Bit-Serial Stored-Program Accumulator Machine

This block is a small stored-program computer that moves every word one digit per clock through a fixed 42-position frame. A frame timer started by a single pulse gives the current position. Sixteen words of memory hold both instructions and data. The machine has an accumulator (rA), a second operand register (rB), a four-bit program counter and a serially filled instruction register. A serial adder, a magnitude comparator and shift logic act on one digit position per clock.

Each instruction takes one frame to fetch and one frame to execute. During the fetch frame only the address and operation fields are captured from the instruction word. The execute frame streams the addressed memory word past the datapath. A halt order parks the machine with its state held. A start pulse runs the program again from address 0. Memory keeps its contents across runs. While the machine is stopped, a load port writes whole words into memory.

Word layout, where bit i of a word is frame position pi: p0–p6 and p38–p41 are spacing. p7 is the least significant digit and p36 the most significant. p37 is the sign, where 1 means positive.

Top module: `serial_accum_cpu`

## Requirements
- R1: After reset, stopped is 1, pc_out is 0 and ra_word is 0.
- R2: One frame is 42 clocks. Every instruction takes exactly 84 clocks: a fetch frame and then an execute frame. A program of N instructions that ends in a halt raises stopped exactly 84·N clocks after the clock edge that samples start.
- R3: The instruction's 4-bit address m is read from p30 (LSB) to p33. Its 3-bit operation code is read from p34 (LSB) to p36. Every other bit of an instruction word is ignored. Address m selects word m, so channel m[3:2] and slot m[1:0]; for example m=8 is slot 0 of channel 2.
- R4: Op 000 copies word m into rA, all 42 positions.
- R5: Op 001 writes rA into word m and leaves rA unchanged. Instructions and data share memory, so a stored word can later run as an instruction.
- R6: Op 010 stops the machine. While stopped, rA and pc hold. A start pulse restarts execution at address 0 with memory kept.
- R7: Op 011 loads m into the program counter.
- R8: Op 100 copies word m into rB. It adds p7–p36 of rB to rA as 30-bit unsigned numbers, keeps the sum modulo 2^30 in rA, and leaves rA's sign and spacing bits unchanged.
- R9: Op 101 loads m into the program counter only when rA[36:7] is strictly greater than rB[36:7].
- R10: Op 110 moves rA[37:8] down to rA[36:7] and clears p37.
- R11: Op 111 moves rA[36:7] up to rA[37:8] and clears p7.
- R12: The program counter increases by one, modulo 16, at the end of each fetch frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock pulse that starts a run from address 0 while stopped |
| ld_we | input | 1 | Write ld_word into memory; acted on only while stopped |
| ld_addr | input | 4 | Memory word to write |
| ld_word | input | 42 | Word to write, bit i at frame position pi |
| stopped | output | 1 | Machine halted |
| pc_out | output | 4 | Program counter |
| ra_word | output | 42 | Accumulator contents |

## Verification
A wrong frame count or phase shifts every halt away from its 84·N clock boundary, and a single run shows it. A wrong field position or address split loads the wrong word into rA. Usually the value is wildly different, and because instruction words carry random bits outside the decoded field, a decoder that strays outside the field goes wrong at once. Wrong carry, compare or shift handling appears in rA, or in the halt address after a conditional transfer, in the same run.

// File: rtl/sac_pkg.sv
package sac_pkg;
    localparam int WORD_LEN  = 42;
    localparam int POS_W     = $clog2(WORD_LEN);
    localparam int NUM_LO    = 7;
    localparam int NUM_HI    = 36;
    localparam int SIGN_POS  = NUM_HI + 1;
    localparam int ADDR_W    = 4;
    localparam int ADDR_LO   = 30;
    localparam int OP_W      = 3;
    localparam int OP_LO     = ADDR_LO + ADDR_W;
    localparam int CHAN_W    = 2;
    localparam int SLOT_W    = ADDR_W - CHAN_W;
    localparam int CHANNELS  = 1 << CHAN_W;
    localparam int SLOTS     = 1 << SLOT_W;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 3'b000,
        OP_STORE = 3'b001,
        OP_HALT  = 3'b010,
        OP_JUMP  = 3'b011,
        OP_ADD   = 3'b100,
        OP_CMPGT = 3'b101,
        OP_SHR   = 3'b110,
        OP_SHL   = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_EXEC  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   ir_addr;
        logic [OP_W-1:0]     ir_op;
        logic [WORD_LEN-1:0] ra;
        logic [WORD_LEN-1:0] rb;
        logic                carry;
        logic                gt;
        logic                behind;
    } core_st_t;
endpackage

// File: rtl/sac_frame_timer.sv
module sac_frame_timer
    import sac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [POS_W-1:0] pos,
    output logic             last
);
    localparam logic [POS_W-1:0] P_LAST = POS_W'(WORD_LEN - 1);

    logic [POS_W-1:0] pos_d, pos_q;

    assign last = run && (pos_q == P_LAST);
    assign pos  = pos_q;

    always_comb begin
        pos_d = pos_q + POS_W'(1);
        if (!run || last) begin
            pos_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end
endmodule

// File: rtl/sac_store.sv
module sac_store
    import sac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_we,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [WORD_LEN-1:0] ld_word,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [POS_W-1:0]    pos,
    input  logic                bit_we,
    input  logic                bit_in,
    output logic                rd_bit
);
    logic [CHAN_W-1:0] ld_chan, acc_chan;
    logic [SLOT_W-1:0] ld_slot, acc_slot;
    logic [CHANNELS-1:0] chan_bit;

    assign ld_chan  = ld_addr[ADDR_W-1 -: CHAN_W];
    assign ld_slot  = ld_addr[SLOT_W-1:0];
    assign acc_chan = acc_addr[ADDR_W-1 -: CHAN_W];
    assign acc_slot = acc_addr[SLOT_W-1:0];
    assign rd_bit   = chan_bit[acc_chan];

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic [WORD_LEN-1:0] words_q [SLOTS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SLOTS; s++) words_q[s] <= '0;
            end else if (ld_we && ld_chan == CHAN_W'(c)) begin
                words_q[ld_slot] <= ld_word;
            end else if (bit_we && acc_chan == CHAN_W'(c)) begin
                words_q[acc_slot][pos] <= bit_in;
            end
        end

        assign chan_bit[c] = words_q[acc_slot][pos];
    end
endmodule

// File: rtl/sac_bit_alu.sv
module sac_bit_alu
    import sac_pkg::*;
(
    input  op_e              op,
    input  logic [POS_W-1:0] pos,
    input  logic             a_bit,
    input  logic             a_ahead,
    input  logic             a_behind,
    input  logic             m_bit,
    input  logic             b_bit,
    input  logic             carry_in,
    input  logic             gt_in,
    output logic             a_out,
    output logic             carry_out,
    output logic             gt_out
);
    localparam logic [POS_W-1:0] P_NUM_LO = POS_W'(NUM_LO);
    localparam logic [POS_W-1:0] P_NUM_HI = POS_W'(NUM_HI);
    localparam logic [POS_W-1:0] P_SIGN   = POS_W'(SIGN_POS);

    logic numeric;
    assign numeric = (pos >= P_NUM_LO) && (pos <= P_NUM_HI);

    always_comb begin
        a_out     = a_bit;
        carry_out = carry_in;
        gt_out    = gt_in;
        unique case (op)
            OP_LOAD: a_out = m_bit;
            OP_ADD: begin
                if (numeric) begin
                    a_out     = a_bit ^ m_bit ^ carry_in;
                    carry_out = (a_bit & m_bit) | (carry_in & (a_bit ^ m_bit));
                end
            end
            OP_CMPGT: begin
                if (numeric && (a_bit != b_bit)) gt_out = a_bit;
            end
            OP_SHR: begin
                if (numeric)             a_out = a_ahead;
                else if (pos == P_SIGN)  a_out = 1'b0;
            end
            OP_SHL: begin
                if (pos == P_NUM_LO)                     a_out = 1'b0;
                else if (pos > P_NUM_LO && pos <= P_SIGN) a_out = a_behind;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_accum_cpu.sv
module serial_accum_cpu
    import sac_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                ld_we,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [WORD_LEN-1:0] ld_word,
    output logic                stopped,
    output logic [ADDR_W-1:0]   pc_out,
    output logic [WORD_LEN-1:0] ra_word
);
    localparam logic [POS_W-1:0] P_ADDR_LO = POS_W'(ADDR_LO);
    localparam logic [POS_W-1:0] P_ADDR_HI = POS_W'(ADDR_LO + ADDR_W - 1);
    localparam logic [POS_W-1:0] P_OP_LO   = POS_W'(OP_LO);
    localparam logic [POS_W-1:0] P_OP_HI   = POS_W'(OP_LO + OP_W - 1);
    localparam logic [POS_W-1:0] P_LAST    = POS_W'(WORD_LEN - 1);

    core_st_t q, d;

    logic [POS_W-1:0]  frame_pos;
    logic              frame_last;
    logic [ADDR_W-1:0] acc_addr;
    logic              mem_bit;
    logic              store_we;
    logic              a_ahead;
    logic              alu_a, alu_carry, alu_gt;
    op_e               cur_op;
    phase_e            phase_now;

    assign phase_now = q.phase;
    assign cur_op    = op_e'(q.ir_op);
    assign stopped   = (q.phase == PH_IDLE);
    assign pc_out    = q.pc;
    assign ra_word   = q.ra;
    assign acc_addr  = (q.phase == PH_FETCH) ? q.pc : q.ir_addr;
    assign store_we  = (q.phase == PH_EXEC) && (cur_op == OP_STORE);
    assign a_ahead   = (frame_pos == P_LAST) ? 1'b0 : q.ra[frame_pos + POS_W'(1)];

    sac_frame_timer u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.phase != PH_IDLE),
        .pos  (frame_pos),
        .last (frame_last)
    );

    sac_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (ld_we && (q.phase == PH_IDLE)),
        .ld_addr (ld_addr),
        .ld_word (ld_word),
        .acc_addr(acc_addr),
        .pos     (frame_pos),
        .bit_we  (store_we),
        .bit_in  (q.ra[frame_pos]),
        .rd_bit  (mem_bit)
    );

    sac_bit_alu u_alu (
        .op       (cur_op),
        .pos      (frame_pos),
        .a_bit    (q.ra[frame_pos]),
        .a_ahead  (a_ahead),
        .a_behind (q.behind),
        .m_bit    (mem_bit),
        .b_bit    (q.rb[frame_pos]),
        .carry_in (q.carry),
        .gt_in    (q.gt),
        .a_out    (alu_a),
        .carry_out(alu_carry),
        .gt_out   (alu_gt)
    );

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase = PH_FETCH;
                    d.pc    = '0;
                end
            end
            PH_FETCH: begin
                // fields arrive least significant digit first: shift in from the top
                if (frame_pos >= P_ADDR_LO && frame_pos <= P_ADDR_HI)
                    d.ir_addr = {mem_bit, q.ir_addr[ADDR_W-1:1]};
                if (frame_pos >= P_OP_LO && frame_pos <= P_OP_HI)
                    d.ir_op = {mem_bit, q.ir_op[OP_W-1:1]};
                if (frame_last) begin
                    d.pc     = q.pc + ADDR_W'(1);
                    d.phase  = PH_EXEC;
                    d.carry  = 1'b0;
                    d.gt     = 1'b0;
                    d.behind = 1'b0;
                end
            end
            PH_EXEC: begin
                d.ra[frame_pos] = alu_a;
                d.carry         = alu_carry;
                d.gt            = alu_gt;
                d.behind        = q.ra[frame_pos];
                if (cur_op == OP_ADD) d.rb[frame_pos] = mem_bit;
                if (frame_last) begin
                    d.phase = PH_FETCH;
                    unique case (cur_op)
                        OP_HALT:  d.phase = PH_IDLE;
                        OP_JUMP:  d.pc    = q.ir_addr;
                        OP_CMPGT: if (q.gt) d.pc = q.ir_addr;
                        default: ;
                    endcase
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sac_checker.sv
module sac_checker
    import sac_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                stopped,
    input logic [ADDR_W-1:0]   pc_out,
    input logic [WORD_LEN-1:0] ra_word,
    input logic [POS_W-1:0]    pos,
    input logic                last,
    input phase_e              phase
);
    localparam logic [POS_W-1:0] P_LAST = POS_W'(WORD_LEN - 1);

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= P_LAST);

    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && pos == P_LAST) |=> pos == '0);

    assert_frame_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && pos != P_LAST) |=> pos == $past(pos) + POS_W'(1));

    assert_fetch_keeps_ra_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> $stable(ra_word));

    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !start) |=> (stopped && $stable(ra_word) && $stable(pc_out)));

    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && start) |=> (!stopped && pc_out == '0 && pos == '0));

    assert_pc_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && last) |=> pc_out == $past(pc_out) + ADDR_W'(1));
endmodule

bind serial_accum_cpu sac_checker u_sac_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .stopped(stopped),
    .pc_out (pc_out),
    .ra_word(ra_word),
    .pos    (frame_pos),
    .last   (frame_last),
    .phase  (phase_now)
);

// File: tb/serial_accum_cpu_test.sv
`timescale 1ns/1ps
module serial_accum_cpu_test;
    import sac_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [41:0] ld_word = '0;
    logic        stopped;
    logic [3:0]  pc_out;
    logic [41:0] ra_word;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    serial_accum_cpu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_word(ld_word), .stopped(stopped),
        .pc_out(pc_out), .ra_word(ra_word)
    );

    task automatic check(input string req, input logic [41:0] act, input logic [41:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [41:0] w);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a[3:0]; ld_word = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run_prog(output int cyc);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!stopped && cyc < 4000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
    endtask

    // instruction with random junk outside p30..p36 (must be ignored, R3)
    function automatic logic [41:0] ins(input op_e op, input int a);
        logic [41:0] w;
        w = {10'($urandom), 32'($urandom)};
        w[33:30] = a[3:0];
        w[36:34] = op;
        return w;
    endfunction

    function automatic logic [41:0] rnd_data();
        logic [41:0] w;
        w = '0;
        w[36:7] = 30'($urandom);
        w[37] = 1'($urandom);
        return w;
    endfunction

    function automatic logic [41:0] f_add(input logic [41:0] x, input logic [41:0] y);
        logic [41:0] r;
        r = x;
        r[36:7] = x[36:7] + y[36:7];
        return r;
    endfunction

    function automatic logic [41:0] f_shr(input logic [41:0] x);
        logic [41:0] r;
        r = x;
        r[37:7] = {1'b0, x[37:8]};
        return r;
    endfunction

    function automatic logic [41:0] f_shl(input logic [41:0] x);
        logic [41:0] r;
        r = x;
        r[37:7] = {x[36:7], 1'b0};
        return r;
    endfunction

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        int cyc;
        logic [41:0] dat [16];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 stopped", 42'(stopped), 42'(1));
        check("R1 pc", 42'(pc_out), 42'(0));
        check("R1 ra", ra_word, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: address 8 is slot 0 of channel 2
        for (int a = 8; a < 16; a++) begin dat[a] = rnd_data(); put(a, dat[a]); end
        put(0, ins(OP_LOAD, 8));
        put(1, ins(OP_HALT, 0));
        run_prog(cyc);
        check("R3 R4 load word 8", ra_word, dat[8]);
        check("R2 two instr cycles", 42'(cyc), 42'(168));
        check("R12 pc after halt", 42'(pc_out), 42'(2));

        // R8: carry out of the top digit discarded, sign kept
        dat[9] = '0; dat[9][36:7] = '1; dat[9][37] = 1'b1;
        dat[10] = '0; dat[10][7] = 1'b1;
        put(9, dat[9]); put(10, dat[10]);
        put(0, ins(OP_LOAD, 9));
        put(1, ins(OP_ADD, 10));
        put(2, ins(OP_HALT, 0));
        run_prog(cyc);
        check("R8 wrap add", ra_word, f_add(dat[9], dat[10]));

        // constrained random programs
        for (int t = 0; t < 40; t++) begin
            int kind, a, b;
            logic [41:0] e;
            for (int w = 8; w < 16; w++) begin dat[w] = rnd_data(); put(w, dat[w]); end
            dat[7] = '0; put(7, '0);
            kind = int'($urandom % 5);
            a = 8 + int'($urandom % 8);
            b = 8 + int'($urandom % 8);
            if (kind == 0) begin
                put(0, ins(OP_LOAD, a)); put(1, ins(OP_HALT, 0));
                run_prog(cyc);
                check("R4 load", ra_word, dat[a]);
                check("R2 cycles", 42'(cyc), 42'(168));
            end else if (kind == 1) begin
                put(0, ins(OP_LOAD, a)); put(1, ins(OP_ADD, b)); put(2, ins(OP_HALT, 0));
                run_prog(cyc);
                check("R8 add", ra_word, f_add(dat[a], dat[b]));
                check("R2 cycles", 42'(cyc), 42'(252));
            end else if (kind == 2) begin
                put(0, ins(OP_LOAD, a)); put(1, ins(OP_SHR, 0)); put(2, ins(OP_HALT, 0));
                run_prog(cyc);
                check("R10 shift right", ra_word, f_shr(dat[a]));
            end else if (kind == 3) begin
                put(0, ins(OP_LOAD, a)); put(1, ins(OP_SHL, 0)); put(2, ins(OP_HALT, 0));
                run_prog(cyc);
                check("R11 shift left", ra_word, f_shl(dat[a]));
            end else begin
                if ($urandom % 4 == 0) b = a;
                put(0, ins(OP_LOAD, 7)); put(1, ins(OP_ADD, b)); put(2, ins(OP_LOAD, a));
                put(3, ins(OP_CMPGT, 5)); put(4, ins(OP_HALT, 0)); put(5, ins(OP_HALT, 0));
                run_prog(cyc);
                e = (dat[a][36:7] > dat[b][36:7]) ? 42'(6) : 42'(5);
                check("R9 compare transfer", 42'(pc_out), e);
                check("R2 cycles", 42'(cyc), 42'(420));
            end
        end

        // R5: store keeps rA, later run sees the word (R6 memory kept)
        put(0, ins(OP_LOAD, 9)); put(1, ins(OP_STORE, 4)); put(2, ins(OP_HALT, 0));
        put(4, '0);
        run_prog(cyc);
        check("R5 ra unchanged by store", ra_word, dat[9]);
        put(0, ins(OP_LOAD, 7)); put(1, ins(OP_LOAD, 4)); put(2, ins(OP_HALT, 0));
        run_prog(cyc);
        check("R5 R6 stored word read back", ra_word, dat[9]);

        // R5: stored word executes as an instruction
        dat[10] = ins(OP_HALT, 0); put(10, dat[10]);
        put(0, ins(OP_LOAD, 10)); put(1, ins(OP_STORE, 2)); put(2, ins(OP_JUMP, 9));
        run_prog(cyc);
        check("R5 self modify pc", 42'(pc_out), 42'(3));
        check("R5 self modify cycles", 42'(cyc), 42'(252));

        // R7 jump
        put(0, ins(OP_JUMP, 5)); put(1, ins(OP_HALT, 0));
        put(5, ins(OP_LOAD, 9)); put(6, ins(OP_HALT, 0));
        run_prog(cyc);
        check("R7 jump pc", 42'(pc_out), 42'(7));
        check("R7 jump ra", ra_word, dat[9]);

        // R6: state holds while stopped, loads do not touch rA
        repeat (20) @(negedge clk);
        put(3, rnd_data());
        check("R6 hold stopped", 42'(stopped), 42'(1));
        check("R6 hold ra", ra_word, dat[9]);
        check("R6 hold pc", 42'(pc_out), 42'(7));

        // R12 wrap from 15 to 0
        put(0, ins(OP_JUMP, 15)); put(15, ins(OP_HALT, 0));
        run_prog(cyc);
        check("R12 pc wrap", 42'(pc_out), 42'(0));
        check("R2 wrap cycles", 42'(cyc), 42'(168));

        finish_run();
    end
endmodule